// File: doc/BRIEF.md
# Handshaked Parallel Sample Output Port

This block moves 16-bit receiver samples off the chip over a parallel bus, one word per port clock, under a request/acknowledge handshake. Each sample that enters from the core side carries an in-phase value, a quadrature value, a 12-bit signal-strength value and a 2-bit tag. The block breaks it into bus words: the in-phase word, then the quadrature word, then, in gain-control mode with strength reporting on, a strength word. Every word goes out with a flag that marks in-phase words and a 2-bit sideband field. In channel mode the sideband field is the channel number. In gain-control mode its low bit names the gain-control source and its high bit marks the strength word.

The port clock comes from one of two places. In master mode it is the core clock divided by 1, 2, 4 or 8, and the block drives it out. In slave mode the receiving device supplies it, with no phase or frequency relation to the core clock. A gray-coded asynchronous FIFO carries the formatted words from the core clock domain into the port clock domain. After reset the block is in slave mode and does not drive its clock pin.

Top module: `pport_top`

## Requirements
- R1: After reset the clock output enable is low (slave mode), the request is low, the output word, in-phase flag and sideband field are all zero, and the sample input is ready.
- R2: With master mode selected, the clock output enable is high and the output clock period is 2^div core clock periods, where div is the 2-bit divisor field (0 to 3).
- R3: The request is high only while words remain pending inside the block, stays high while any remain, and is low once the last word has been shifted out.
- R4: On a port clock rising edge where the acknowledge input is low, or the request was low before the edge, the output word, flag and sideband field do not change.
- R5: On a port clock rising edge where the request was high and the acknowledge input is high, the next pending word appears on the outputs at that edge, so that data follows a rising acknowledge by at most one port clock.
- R6: With the acknowledge held high, the first word appears at the port clock edge that follows the edge at which the request rose.
- R7: The in-phase flag is 1 for an in-phase word and 0 for quadrature and strength words.
- R8: In channel mode the sideband field equals the 2-bit tag of the sample, for both of its words, and no strength word is sent.
- R9: In gain-control mode the sideband bit 0 is the tag's bit 0 (0 = source A, 1 = source B) and bit 1 is 1 only for the strength word. With strength reporting on, a third word follows the quadrature word, holding the 12-bit strength value in bits 15:4 and zeros in bits 3:0; with it off, only two words are sent.
- R10: Words leave in the order the samples were accepted, in-phase before quadrature before strength, with none lost or repeated.
- R11: In slave mode the port logic runs on the external clock input and the handshake behaves as in R3 to R5 when that clock is asynchronous to the core clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_master | input | 1 | 1 = generate the port clock, 0 = take it from port_clk_in |
| cfg_clk_div | input | 2 | Master-mode divisor select: 0..3 gives divide by 1, 2, 4, 8 |
| cfg_agc_mode | input | 1 | 1 = gain-control tagging, 0 = channel tagging |
| cfg_rssi_en | input | 1 | Send a strength word after each sample in gain-control mode |
| in_valid | input | 1 | Sample present on the input lines |
| in_ready | output | 1 | Block accepts a sample at this core clock edge |
| in_i | input | 16 | In-phase value |
| in_q | input | 16 | Quadrature value |
| in_rssi | input | 12 | Signal strength value |
| in_tag | input | 2 | Channel number or gain-control source in bit 0 |
| port_clk_in | input | 1 | External port clock for slave mode |
| port_clk_out | output | 1 | Generated port clock |
| port_clk_oe | output | 1 | Drive enable for the port clock pin |
| xfer_ack | input | 1 | Acknowledge from the receiver, sampled on the port clock |
| xfer_req | output | 1 | Words pending, synchronous to the port clock |
| out_word | output | 16 | Output data word |
| out_is_i | output | 1 | High when an in-phase word is on the bus |
| out_tag | output | 2 | Sideband field |

## Verification
A wrong read pointer or a stale empty flag in the crossing FIFO shows up at the first shifted word as a repeated, skipped or out-of-order word, or as a request that stays high after the last word. A formatter that sits in the wrong state shows up within one sample as a wrong flag, a wrong sideband field or a missing or extra strength word. Handshake timing faults are visible at the same port clock edge, because the bench predicts from the request and acknowledge it sampled whether the bus must change at each edge, and checks that it holds still otherwise.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DW = 16;
  localparam int RW = 12;
  localparam int TW = 2;

  typedef struct packed {
    logic          is_i;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
  } pword_t;

  localparam int PWORD_W = $bits(pword_t);

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_I    = 2'd1,
    FS_Q    = 2'd2,
    FS_R    = 2'd3
  } fmt_state_e;
endpackage

// File: rtl/pport_rst_sync.sv
module pport_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pport_clkgen.sv
module pport_clkgen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             ext_clk,
  output logic             gen_clk,
  output logic             port_clk,
  output logic             master_q
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W:0]   taps;

  always_comb cnt_n = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      div_q    <= '0;
      master_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      div_q    <= cfg_div;
      master_q <= cfg_master;
    end
  end

  // tap 0 is the core clock itself, tap k is counter bit k-1 (divide by 2^k)
  assign taps     = {cnt_q, clk};
  assign gen_clk  = taps[div_q];
  assign port_clk = master_q ? gen_clk : ext_clk;
endmodule

// File: rtl/pport_fmt.sv
module pport_fmt
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_agc_mode,
  input  logic          cfg_rssi_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [RW-1:0] in_rssi,
  input  logic [TW-1:0] in_tag,
  input  logic          wr_full,
  output logic          wr_en,
  output pword_t        wr_word
);
  fmt_state_e    st_q, st_n;
  logic [DW-1:0] i_q, q_q;
  logic [RW-1:0] r_q;
  logic [TW-1:0] tag_q;
  logic          agc_q, rssi_q;
  logic          cap_en;
  logic [TW-1:0] iq_tag;

  assign in_ready = (st_q == FS_IDLE);
  assign cap_en   = in_ready && in_valid;
  assign iq_tag   = agc_q ? {1'b0, tag_q[0]} : tag_q;

  always_comb begin
    st_n    = st_q;
    wr_en   = 1'b0;
    wr_word = '0;
    case (st_q)
      FS_IDLE: if (cap_en) st_n = FS_I;
      FS_I: begin
        wr_en   = !wr_full;
        wr_word = '{is_i: 1'b1, tag: iq_tag, data: i_q};
        if (!wr_full) st_n = FS_Q;
      end
      FS_Q: begin
        wr_en   = !wr_full;
        wr_word = '{is_i: 1'b0, tag: iq_tag, data: q_q};
        if (!wr_full) st_n = (agc_q && rssi_q) ? FS_R : FS_IDLE;
      end
      FS_R: begin
        wr_en   = !wr_full;
        wr_word = '{is_i: 1'b0, tag: {1'b1, tag_q[0]},
                    data: {r_q, {(DW-RW){1'b0}}}};
        if (!wr_full) st_n = FS_IDLE;
      end
      default: st_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q    <= '0;
      q_q    <= '0;
      r_q    <= '0;
      tag_q  <= '0;
      agc_q  <= 1'b0;
      rssi_q <= 1'b0;
    end else if (cap_en) begin
      i_q    <= in_i;
      q_q    <= in_q;
      r_q    <= in_rssi;
      tag_q  <= in_tag;
      agc_q  <= cfg_agc_mode;
      rssi_q <= cfg_rssi_en;
    end
  end

  // R10: an accepted sample is followed by an attempt to push its in-phase word
  a_r10_accept_then_i: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (st_q == FS_I) && wr_word.is_i);
endmodule

// File: rtl/pport_afifo.sv
module pport_afifo
  import pport_pkg::*;
#(
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic   wclk,
  input  logic   wrst_n,
  input  logic   push,
  input  pword_t wdata,
  output logic   wfull,
  input  logic   rclk,
  input  logic   rrst_n,
  input  logic   pop,
  output pword_t rdata,
  output logic   rempty
);
  localparam int DEPTH = 1 << AW;

  pword_t mem [DEPTH];

  logic [AW:0] wbin_q, wbin_n, wgray_q, wgray_n;
  logic [AW:0] rbin_q, rbin_n, rgray_q, rgray_n;
  logic [AW:0] rg_sync [SYNC];
  logic [AW:0] wg_sync [SYNC];
  logic        wfull_n, rempty_n;

  // write side
  always_comb begin
    wbin_n  = wbin_q + {{AW{1'b0}}, (push && !wfull)};
    wgray_n = wbin_n ^ (wbin_n >> 1);
    wfull_n = (wgray_n == {~rg_sync[SYNC-1][AW:AW-1], rg_sync[SYNC-1][AW-2:0]});
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      wfull   <= 1'b0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wgray_n;
      wfull   <= wfull_n;
    end
  end

  always_ff @(posedge wclk) begin
    if (push && !wfull) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // read side
  always_comb begin
    rbin_n   = rbin_q + {{AW{1'b0}}, (pop && !rempty)};
    rgray_n  = rbin_n ^ (rbin_n >> 1);
    rempty_n = (rgray_n == wg_sync[SYNC-1]);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rempty  <= 1'b1;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rgray_n;
      rempty  <= rempty_n;
    end
  end

  assign rdata = mem[rbin_q[AW-1:0]];

  // pointer synchronizers
  generate
    for (genvar s = 0; s < SYNC; s++) begin : g_sync
      always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n)    rg_sync[s] <= '0;
        else if (s == 0) rg_sync[s] <= rgray_q;
        else            rg_sync[s] <= rg_sync[(s == 0) ? 0 : s-1];
      end
      always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n)    wg_sync[s] <= '0;
        else if (s == 0) wg_sync[s] <= wgray_q;
        else            wg_sync[s] <= wg_sync[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // R3: pending words never vanish without being read
  a_r3_pending_kept: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!rempty && !pop) |=> !rempty);
endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
  import pport_pkg::*;
(
  input  logic          pclk,
  input  logic          prst_n,
  input  logic          pending,
  input  logic          ack,
  input  pword_t        head,
  output logic          pop,
  output logic          req,
  output logic [DW-1:0] word,
  output logic          is_i,
  output logic [TW-1:0] tag
);
  pword_t out_q, out_n;

  assign req = pending;
  assign pop = pending && ack;

  always_comb begin
    out_n = out_q;
    if (pop) out_n = head;
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) out_q <= '0;
    else         out_q <= out_n;
  end

  assign word = out_q.data;
  assign is_i = out_q.is_i;
  assign tag  = out_q.tag;

  // R4: without a sampled handshake the bus holds still
  a_r4_hold: assert property (@(posedge pclk) disable iff (!prst_n)
    !(req && ack) |=> $stable(word) && $stable(is_i) && $stable(tag));

  // R5: a sampled handshake puts the FIFO head on the bus at that edge
  a_r5_shift: assert property (@(posedge pclk) disable iff (!prst_n)
    (req && ack) |=> (word == $past(head.data)) && (is_i == $past(head.is_i)));
endmodule

// File: rtl/pport_top.sv
module pport_top
  import pport_pkg::*;
#(
  parameter int FIFO_AW = 3,
  parameter int SYNC    = 2,
  parameter int DIV_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clk_master,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic             cfg_agc_mode,
  input  logic             cfg_rssi_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_i,
  input  logic [DW-1:0]    in_q,
  input  logic [RW-1:0]    in_rssi,
  input  logic [TW-1:0]    in_tag,
  input  logic             port_clk_in,
  output logic             port_clk_out,
  output logic             port_clk_oe,
  input  logic             xfer_ack,
  output logic             xfer_req,
  output logic [DW-1:0]    out_word,
  output logic             out_is_i,
  output logic [TW-1:0]    out_tag
);
  logic   crst_n, prst_n;
  logic   port_clk, gen_clk, master_q;
  logic   wr_en, wr_full, rd_pop, rd_empty;
  pword_t wr_word, rd_head;

  pport_rst_sync #(.STAGES(SYNC)) u_crst (
    .clk(clk), .arst_n(rst_n), .srst_n(crst_n));

  pport_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(crst_n), .cfg_master(cfg_clk_master),
    .cfg_div(cfg_clk_div), .ext_clk(port_clk_in), .gen_clk(gen_clk),
    .port_clk(port_clk), .master_q(master_q));

  assign port_clk_out = gen_clk;
  assign port_clk_oe  = master_q;

  pport_rst_sync #(.STAGES(SYNC)) u_prst (
    .clk(port_clk), .arst_n(rst_n), .srst_n(prst_n));

  pport_fmt u_fmt (
    .clk(clk), .rst_n(crst_n), .cfg_agc_mode(cfg_agc_mode),
    .cfg_rssi_en(cfg_rssi_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .in_rssi(in_rssi), .in_tag(in_tag),
    .wr_full(wr_full), .wr_en(wr_en), .wr_word(wr_word));

  pport_afifo #(.AW(FIFO_AW), .SYNC(SYNC)) u_fifo (
    .wclk(clk), .wrst_n(crst_n), .push(wr_en), .wdata(wr_word),
    .wfull(wr_full), .rclk(port_clk), .rrst_n(prst_n), .pop(rd_pop),
    .rdata(rd_head), .rempty(rd_empty));

  pport_ctl u_ctl (
    .pclk(port_clk), .prst_n(prst_n), .pending(!rd_empty), .ack(xfer_ack),
    .head(rd_head), .pop(rd_pop), .req(xfer_req), .word(out_word),
    .is_i(out_is_i), .tag(out_tag));
endmodule

// File: tb/tb_pport_top.sv
`timescale 1ns/1ps
module tb_pport_top;
  logic        clk = 1'b0;
  logic        ext_clk = 1'b0;
  logic        rst_n;
  logic        cfg_clk_master, cfg_agc_mode, cfg_rssi_en;
  logic [1:0]  cfg_clk_div;
  logic        in_valid, in_ready;
  logic [15:0] in_i, in_q;
  logic [11:0] in_rssi;
  logic [1:0]  in_tag;
  logic        port_clk_out, port_clk_oe, xfer_ack, xfer_req, out_is_i;
  logic [15:0] out_word;
  logic [1:0]  out_tag;
  logic        mon_clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, mon_en = 0, prev_req = 0, prev2_req = 0;
  int ack_mode = 1;  // 0 high, 1 low, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  logic [18:0] last_out;
  logic [18:0] exp_q [$];

  always #2.5 clk = ~clk;
  always #3.5 ext_clk = ~ext_clk;
  assign mon_clk = cfg_clk_master ? port_clk_out : ext_clk;

  pport_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_master(cfg_clk_master),
    .cfg_clk_div(cfg_clk_div), .cfg_agc_mode(cfg_agc_mode),
    .cfg_rssi_en(cfg_rssi_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .in_rssi(in_rssi), .in_tag(in_tag),
    .port_clk_in(ext_clk), .port_clk_out(port_clk_out),
    .port_clk_oe(port_clk_oe), .xfer_ack(xfer_ack), .xfer_req(xfer_req),
    .out_word(out_word), .out_is_i(out_is_i), .out_tag(out_tag));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, expv, $time);
    end
  endtask

  // acknowledge driver: changes 2 ns after each port clock edge
  always @(posedge mon_clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ack_mode)
      0:       xfer_ack = 1'b1;
      1:       xfer_ack = 1'b0;
      default: xfer_ack = lfsr[0] | lfsr[3];
    endcase
  end

  // reference model, evaluated 1 ns after each port clock edge
  always @(posedge mon_clk) begin
    #1;
    if (mon_en) begin
      logic [18:0] cur, e;
      cur = {out_is_i, out_tag, out_word};
      if (prev_req && xfer_ack) begin
        if (exp_q.size() == 0) chk(0, "R3 shift with nothing pending", 0, 0);
        else begin
          e = exp_q.pop_front();
          if (!prev2_req && ack_mode == 0)
            chk(cur == e, "R6 first word after request", 32'(cur), 32'(e));
          else
            chk(cur == e, "R5/R7/R8/R9/R10/R11 shifted word", 32'(cur), 32'(e));
        end
      end else begin
        chk(cur == last_out, "R4 bus hold", 32'(cur), 32'(last_out));
      end
      chk(!(xfer_req && exp_q.size() == 0), "R3 request without data",
          32'(xfer_req), 0);
      last_out  = cur;
      prev2_req = prev_req;
      prev_req  = xfer_req;
    end
  end

  task automatic mon_start();
    @(posedge mon_clk); #1;
    last_out  = {out_is_i, out_tag, out_word};
    prev_req  = xfer_req;
    prev2_req = xfer_req;
    mon_en    = 1;
  endtask

  task automatic send(input logic [15:0] i, input logic [15:0] q,
                      input logic [11:0] r, input logic [1:0] t);
    logic [1:0] iqt;
    @(posedge clk); #1;
    in_valid = 1; in_i = i; in_q = q; in_rssi = r; in_tag = t;
    forever begin
      bit rdy;
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
    end
    iqt = cfg_agc_mode ? {1'b0, t[0]} : t;
    exp_q.push_back({1'b1, iqt, i});
    exp_q.push_back({1'b0, iqt, q});
    if (cfg_agc_mode && cfg_rssi_en) exp_q.push_back({1'b0, 1'b1, t[0], r, 4'h0});
    #1 in_valid = 0;
  endtask

  task automatic drain(input string rq);
    wait (exp_q.size() == 0);
    repeat (4) @(posedge mon_clk);
    #1 chk(xfer_req == 0, rq, 32'(xfer_req), 0);
    mon_en = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_clk_master = 0; cfg_clk_div = 0; cfg_agc_mode = 0;
    cfg_rssi_en = 0; in_valid = 0; in_i = 0; in_q = 0; in_rssi = 0;
    in_tag = 0; xfer_ack = 0;
    #52 rst_n = 1;
    #100;
    chk(port_clk_oe == 0, "R1 clock enable", 32'(port_clk_oe), 0);
    chk(xfer_req == 0, "R1 request", 32'(xfer_req), 0);
    chk({out_is_i, out_tag, out_word} == 0, "R1 bus", 32'(out_word), 0);
    chk(in_ready == 1, "R1 input ready", 32'(in_ready), 1);

    // R2: divisor sweep
    cfg_clk_master = 1;
    for (int d = 0; d < 4; d++) begin
      realtime t0, t1;
      cfg_clk_div = 2'(d);
      #100;
      @(posedge port_clk_out); t0 = $realtime;
      @(posedge port_clk_out); t1 = $realtime;
      chk((t1 - t0) > (5.0 * (1 << d)) - 0.01 && (t1 - t0) < (5.0 * (1 << d)) + 0.01,
          "R2 period", 32'(int'(t1 - t0)), 32'(5 * (1 << d)));
      chk(port_clk_oe == 1, "R2 clock enable", 32'(port_clk_oe), 1);
    end

    // channel mode, divide by 1, acknowledge held high
    cfg_clk_div = 0; ack_mode = 0; #100;
    mon_start();
    for (int k = 0; k < 8; k++)
      send(16'h1000 + 16'(k), 16'h2000 + 16'(k), 12'h0, 2'(k));
    drain("R3 request low after drain");

    // gain-control mode with strength word, divide by 4, random acknowledge
    cfg_clk_div = 2; cfg_agc_mode = 1; cfg_rssi_en = 1; ack_mode = 2; #200;
    mon_start();
    for (int k = 0; k < 6; k++)
      send(16'h3100 + 16'(k), 16'h3200 + 16'(k), 12'hA50 + 12'(k), 2'(k));
    drain("R3 request low after drain");

    // gain-control mode without strength word, divide by 2, acknowledge held low
    cfg_clk_div = 1; cfg_rssi_en = 0; ack_mode = 1; #200;
    mon_start();
    for (int k = 0; k < 3; k++)
      send(16'h4100 + 16'(k), 16'h4200 + 16'(k), 12'hFFF, 2'(k + 1));
    #300;
    chk(xfer_req == 1, "R3 request held while pending", 32'(xfer_req), 1);
    ack_mode = 0;
    drain("R3 request low after drain");

    // slave mode on an asynchronous external clock
    cfg_clk_master = 0; cfg_agc_mode = 0; ack_mode = 2; #200;
    chk(port_clk_oe == 0, "R11 clock enable in slave mode", 32'(port_clk_oe), 0);
    mon_start();
    for (int k = 0; k < 10; k++)
      send(16'h5100 + 16'(k), 16'h5200 + 16'(k), 12'h0, 2'(3 - (k % 4)));
    drain("R11 request low after drain");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule